// File: doc/BRIEF.md
# Hamming Sector Check-Code Generator and Single-Bit Corrector

The block streams one sector of bytes, one byte per accepted cycle, and builds a Hamming check code over it. With the default 512-byte sector the code is 24 bits (three bytes). It has twelve bit pairs. Pairs 0 to 2 are column parities taken over bit positions inside a byte. Pairs 3 to 11 are row parities taken over byte addresses. In each pair the odd bit covers the half whose index bit is 1, and the even bit covers the half whose index bit is 0. Dropping the enable input clears the accumulated parity, and raising it again starts a fresh sector. The code is marked ready once the byte flagged as last has been taken.

For correction, the caller XORs the code stored with the sector against the code the block recomputed, and presents the 24-bit syndrome. The block classifies the syndrome and, for a single data-bit error, returns the byte address and the bit number to flip. Keeping the sector data itself is left to the caller.

Top module: `hamming_sector_ecc`

## Requirements
- R1: For each data bit set at bit position b (0..7), pair k (k = 0..2) of `code_out` has odd bit 2k+1 toggled if b has bit k set, and even bit 2k toggled otherwise. The code is the XOR of these contributions over the sector.
- R2: For each data bit set in byte address a, pair 3+j (j = 0..AW-1) has odd bit 2(3+j)+1 toggled if a has bit j set, and even bit 2(3+j) toggled otherwise. Byte addresses count the accepted bytes from 0. `code_out[7:0]` is the least significant code byte.
- R3: `code_ready` goes high in the cycle after the byte with `in_last` is accepted. While it is high, `code_out` holds, and further input bytes are ignored.
- R4: While `en` is low, the accumulated code and the byte count clear to zero and `code_ready` is low on the next cycle. A sector sent after `en` returns high gives a code that does not depend on earlier bytes.
- R5: Cycles with `in_valid` low have no effect, whatever `in_data` and `in_last` carry.
- R6: An all-zero syndrome is reported as `res_kind` = 0 (no error).
- R7: A syndrome in which both bits of every pair differ is reported as `res_kind` = 1 (data error). `res_byte` is taken from the odd bits of pairs 3.. and `res_bit` from the odd bits of pairs 0..2.
- R8: A syndrome with exactly one bit set is reported as `res_kind` = 2 (error in the stored code). `res_byte` and `res_bit` are then 0.
- R9: Any other syndrome is reported as `res_kind` = 3 (uncorrectable), with `res_byte` and `res_bit` at 0.
- R10: `res_valid` is high exactly in the cycle after a cycle with `syn_valid` high. The result fields change only on such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Check-code enable; low clears the accumulation |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the sector |
| code_out | output | CW (24) | Accumulated check code, byte 0 in bits 7:0 |
| code_ready | output | 1 | Code complete for the sector |
| syn_valid | input | 1 | Syndrome present |
| syn_in | input | CW (24) | Stored code XOR recomputed code |
| res_valid | output | 1 | Classification result valid |
| res_kind | output | 2 | 0 none, 1 data error, 2 code error, 3 uncorrectable |
| res_byte | output | AW (9) | Byte address to correct |
| res_bit | output | 3 | Bit number to correct |

## Verification
The bench builds the block with the default 512-byte sector. This makes the 9-bit byte address and the full 24-bit code reachable, including the corner at byte 511, bit 7. Whole sectors of zeros, of ones, with single set bits and with random contents are compared against a code computed bit by bit in the bench. These runs include idle gaps that carry junk data, and an enable drop in the middle of a sector. Syndromes come from single flips at every boundary and at random positions, from each single-bit pattern, from double errors and from random words, and one is formed end to end from a recomputed code.

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc #(
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(SECTOR_BYTES),
  localparam int NP = AW + 3,
  localparam int CW = 2 * NP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic [CW-1:0] code_out,
  output logic          code_ready,
  input  logic          syn_valid,
  input  logic [CW-1:0] syn_in,
  output logic          res_valid,
  output logic [1:0]    res_kind,
  output logic [AW-1:0] res_byte,
  output logic [2:0]    res_bit
);

  function automatic logic [7:0] colmask(input int k);
    for (int i = 0; i < 8; i++) colmask[i] = i[k];
  endfunction

  logic [CW-1:0] acc, flip;
  logic [AW-1:0] cnt;
  logic          ready, take, bpar;
  logic [NP-1:0] pdiff, podd;
  logic [1:0]    kind_n;

  assign take = en & in_valid & ~ready;
  assign bpar = ^in_data;

  for (genvar k = 0; k < 3; k++) begin : g_col
    localparam logic [7:0] M = colmask(k);
    assign flip[2*k+1] = ^(in_data & M);
    assign flip[2*k]   = ^(in_data & ~M);
  end

  for (genvar j = 0; j < AW; j++) begin : g_row
    assign flip[2*(j+3)+1] = bpar & cnt[j];
    assign flip[2*(j+3)]   = bpar & ~cnt[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
      ready <= 1'b0;
    end else if (!en) begin
      acc <= '0;
      cnt <= '0;
      ready <= 1'b0;
    end else if (take) begin
      acc <= acc ^ flip;
      cnt <= cnt + 1'b1;
      if (in_last) ready <= 1'b1;
    end
  end

  assign code_out   = acc;
  assign code_ready = ready;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pdiff[p] = syn_in[2*p+1] ^ syn_in[2*p];
    assign podd[p]  = syn_in[2*p+1];
  end

  always_comb begin
    kind_n = 2'd3;
    if (syn_in == '0)                 kind_n = 2'd0;
    else if ($countones(syn_in) == 1) kind_n = 2'd2;
    else if (&pdiff)                  kind_n = 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= 2'd0;
      res_byte  <= '0;
      res_bit   <= '0;
    end else begin
      res_valid <= syn_valid;
      if (syn_valid) begin
        res_kind <= kind_n;
        res_byte <= (kind_n == 2'd1) ? podd[NP-1:3] : '0;
        res_bit  <= (kind_n == 2'd1) ? podd[2:0] : '0;
      end
    end
  end

endmodule

// File: rtl/hamming_sector_ecc_chk.sv
module hamming_sector_ecc_chk #(
  parameter int AW = 9,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          in_valid,
  input logic          in_last,
  input logic [CW-1:0] code_out,
  input logic          code_ready,
  input logic          syn_valid,
  input logic [CW-1:0] syn_in,
  input logic          res_valid,
  input logic [1:0]    res_kind,
  input logic [AW-1:0] res_byte,
  input logic [2:0]    res_bit
);

  p_ready_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid && in_last && !code_ready |=> code_ready);

  p_hold_while_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready && en |=> code_ready && $stable(code_out));

  p_clear_on_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !code_ready && code_out == '0);

  p_idle_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !in_valid |=> $stable(code_out));

  p_zero_syn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid && syn_in == '0 |=> res_kind == 2'd0);

  p_data_weight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'd1 |-> $countones($past(syn_in)) == CW / 2);

  p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid && $countones(syn_in) == 1 |=> res_kind == 2'd2 && res_byte == '0 && res_bit == '0);

  p_fields_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != 2'd1 |-> res_byte == '0 && res_bit == '0);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |=> res_valid);

  p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_valid |=> !res_valid && $stable(res_kind) && $stable(res_byte) && $stable(res_bit));

endmodule

bind hamming_sector_ecc hamming_sector_ecc_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_last(in_last),
  .code_out(code_out), .code_ready(code_ready), .syn_valid(syn_valid),
  .syn_in(syn_in), .res_valid(res_valid), .res_kind(res_kind),
  .res_byte(res_byte), .res_bit(res_bit)
);

// File: tb/test_hamming_sector_ecc.sv
module test_hamming_sector_ecc;
  localparam int SB = 512;
  localparam int AW = 9;
  localparam int CW = 24;

  logic clk = 0, rst_n = 0, en = 1, in_valid = 0, in_last = 0, syn_valid = 0;
  logic [7:0] in_data = 0;
  logic [CW-1:0] syn_in = 0, code_out;
  logic code_ready, res_valid;
  logic [1:0] res_kind;
  logic [AW-1:0] res_byte;
  logic [2:0] res_bit;
  int errors = 0, checks = 0;
  logic [7:0] sec [SB];

  always #10 clk = ~clk;

  hamming_sector_ecc i_hamming_sector_ecc (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .code_out(code_out), .code_ready(code_ready),
    .syn_valid(syn_valid), .syn_in(syn_in), .res_valid(res_valid),
    .res_kind(res_kind), .res_byte(res_byte), .res_bit(res_bit));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] bitcode(input int a, input int b);
    logic [CW-1:0] c = '0;
    for (int k = 0; k < 3; k++)
      if (((b >> k) & 1) == 1) c[2*k+1] = 1'b1; else c[2*k] = 1'b1;
    for (int j = 0; j < AW; j++)
      if (((a >> j) & 1) == 1) c[2*(j+3)+1] = 1'b1; else c[2*(j+3)] = 1'b1;
    return c;
  endfunction

  function automatic logic [CW-1:0] ref_code();
    logic [CW-1:0] c = '0;
    for (int a = 0; a < SB; a++)
      for (int b = 0; b < 8; b++)
        if (sec[a][b]) c ^= bitcode(a, b);
    return c;
  endfunction

  function automatic logic [1:0] classify(input logic [CW-1:0] s);
    int ones = 0;
    bit alld = 1;
    for (int i = 0; i < CW; i++) ones += int'(s[i]);
    for (int p = 0; p < CW/2; p++) if (s[2*p] == s[2*p+1]) alld = 0;
    if (ones == 0) return 2'd0;
    if (ones == 1) return 2'd2;
    if (alld) return 2'd1;
    return 2'd3;
  endfunction

  task automatic fresh();
    en = 0;
    @(negedge clk);
    check(!code_ready && code_out == 0, "R4 clear on disable", {code_ready, code_out}, 0);
    en = 1;
  endtask

  task automatic send_sector(input bit gaps);
    for (int a = 0; a < SB; a++) begin
      while (gaps && ($urandom % 4) == 0) begin
        in_valid = 0; in_data = 8'($urandom); in_last = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 1; in_data = sec[a]; in_last = (a == SB - 1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic run_sector(input bit gaps, input string tag);
    logic [CW-1:0] exp;
    exp = ref_code();
    fresh();
    send_sector(gaps);
    check(code_ready == 1, {tag, " R3 ready"}, code_ready, 1);
    check(code_out == exp, {tag, " R1 R2 code"}, code_out, exp);
  endtask

  task automatic syn_check(input logic [CW-1:0] s, input logic [1:0] ek,
                           input logic [AW-1:0] eb, input logic [2:0] et, input string tag);
    syn_valid = 1; syn_in = s;
    @(negedge clk);
    syn_valid = 0; syn_in = CW'($urandom);
    check(res_valid && res_kind == ek && res_byte == eb && res_bit == et, tag,
          {res_valid, res_kind, res_byte, res_bit}, {1'b1, ek, eb, et});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [CW-1:0] c0, s;
    logic [1:0] k;
    int a, b, a2, b2;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!code_ready && code_out == 0 && !res_valid, "reset state",
          {code_ready, res_valid, code_out}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < SB; i++) sec[i] = 8'h00;
    run_sector(0, "zeros");
    for (int i = 0; i < SB; i++) sec[i] = 8'hFF;
    run_sector(0, "ones");
    for (int i = 0; i < SB; i++) sec[i] = 8'h00;
    sec[SB-1] = 8'h80;
    run_sector(0, "byte511 bit7");
    sec[SB-1] = 8'h00; sec[0] = 8'h01;
    run_sector(0, "byte0 bit0");
    for (int i = 0; i < SB; i++) sec[i] = 8'($urandom);
    run_sector(0, "random");
    c0 = code_out;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = 8'($urandom); in_last = 1'($urandom);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    check(code_ready && code_out == c0, "R3 bytes ignored while ready", code_out, c0);

    for (int i = 0; i < SB; i++) sec[i] = 8'($urandom);
    run_sector(1, "R5 gaps");

    for (int i = 0; i < 100; i++) begin
      in_valid = 1; in_data = 8'($urandom); in_last = 0;
      @(negedge clk);
    end
    in_valid = 0;
    for (int i = 0; i < SB; i++) sec[i] = 8'($urandom);
    run_sector(1, "R4 fresh after mid-sector drop");

    syn_check('0, 2'd0, '0, '0, "R6 zero syndrome");
    @(negedge clk);
    check(!res_valid && res_kind == 0, "R10 valid one cycle, fields held", {res_valid, res_kind}, 0);
    for (int i = 0; i < CW; i++) syn_check(CW'(1) << i, 2'd2, '0, '0, "R8 single-bit syndrome");
    syn_check(bitcode(0, 0), 2'd1, 9'd0, 3'd0, "R7 byte0 bit0");
    syn_check(bitcode(SB-1, 7), 2'd1, 9'd511, 3'd7, "R7 byte511 bit7");
    for (int i = 0; i < 20; i++) begin
      a = $urandom % SB; b = $urandom % 8;
      syn_check(bitcode(a, b), 2'd1, AW'(a), 3'(b), "R7 random flip");
    end
    for (int i = 0; i < 10; i++) begin
      a = $urandom % SB; b = $urandom % 8;
      a2 = (a + 1 + ($urandom % (SB - 1))) % SB; b2 = $urandom % 8;
      s = bitcode(a, b) ^ bitcode(a2, b2);
      k = classify(s);
      syn_check(s, k, '0, '0, "R9 double error");
    end
    for (int i = 0; i < 20; i++) begin
      s = CW'($urandom);
      k = classify(s);
      if (k == 2'd1) syn_check(s, k, AW'({s[23], s[21], s[19], s[17], s[15], s[13], s[11], s[9], s[7]}),
                               {s[5], s[3], s[1]}, "R7 random syndrome");
      else syn_check(s, k, '0, '0, "R9 random syndrome");
    end

    for (int i = 0; i < SB; i++) sec[i] = 8'($urandom);
    c0 = ref_code();
    a = 300; b = 5;
    sec[a][b] = ~sec[a][b];
    run_sector(0, "flipped sector");
    syn_check(c0 ^ code_out, 2'd1, 9'd300, 3'd5, "R7 end-to-end correction");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule